// File: doc/BRIEF.md
# Cascaded Interrupt Controller Acknowledge Logic

This block pairs two eight-input priority interrupt controllers, a master and a slave, behind one acknowledge path. Each controller holds a request register, a mask register and an in-service register, and has a fixed-priority resolver and a programmable vector base. The slave's combined interrupt feeds the master's input 2, so the sixteen request lines reach the processor through one interrupt output.

The host raises `ack_req` for one cycle to acknowledge. The block turns this into two internal acknowledge pulses on the next two cycles. On the first pulse the resolver result is frozen, the winner moves from request to in-service, and the master latches a 3-bit cascade code. On the second pulse the controller chosen by that code supplies the vector byte, which appears on `vec_data` with `vec_valid` for one cycle. A request that has gone away by the first pulse yields the master's input-7 vector without touching any in-service bit.

Software programs each controller through a small write port. The port sets the vector base, the mask, auto-EOI and level mode, and issues non-specific end-of-interrupt commands.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: The vector byte is {base[7:3], index[2:0]}. Base bits come from `wr_data[7:3]` written at `wr_addr` 0. The index is the acknowledged input number within its controller (0..7).
- R2: In edge mode, a rising edge on a request line sets its request bit until acknowledged. In level mode (`wr_addr` 2, `wr_data[1]`=1) the request bit follows the line, so a line that drops clears it.
- R3: `int_out` is 0 after reset. It goes high one cycle after an unmasked, unblocked request is pending. `wr_addr` 1 writes the mask: bit i=1 masks input i. Reset clears the masks.
- R4: Priority is fixed with input 0 highest. A set in-service bit blocks requests at its own and all lower priorities.
- R5: An `ack_req` seen while idle produces exactly two internal acknowledge pulses on the following two cycles. An `ack_req` during a sequence is ignored.
- R6: On the first pulse the winning input's in-service bit is set and its request bit is cleared.
- R7: `vec_valid` is high for exactly one cycle: the third cycle after the cycle in which `ack_req` was sampled. `vec_data` holds the vector in that cycle.
- R8: `irq_in[15:8]` are slave inputs 0..7, and the slave's interrupt drives master input 2. When the master resolves to input 2, the cascade code is 2 and the slave supplies the vector. `irq_in[2]` has no effect.
- R9: When nothing is pending at the first pulse, the vector is the master's base with index 7, and no in-service bit changes.
- R10: Auto-EOI mode (`wr_addr` 2, `wr_data[0]`=1) clears the in-service bit at the end of the second pulse. Otherwise the bit stays set until an EOI.
- R11: A write to `wr_addr` 3 is a non-specific EOI. It clears the highest-priority set in-service bit of the controller chosen by `wr_slave`. A slave interrupt needs an EOI to both controllers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Request lines; [7:0] master, [15:8] slave |
| wr_en | input | 1 | Register write strobe |
| wr_slave | input | 1 | Write target: 0 master, 1 slave |
| wr_addr | input | 2 | 0 base, 1 mask, 2 mode, 3 EOI |
| wr_data | input | 8 | Write data |
| ack_req | input | 1 | Host acknowledge request |
| int_out | output | 1 | Registered interrupt to the processor |
| vec_valid | output | 1 | Vector byte valid strobe |
| vec_data | output | 8 | Vector byte |

## Verification
The embedded properties check the following on every cycle:
- the two acknowledge pulses always follow one another and never overlap;
- a resolved input lands in service on the cycle after the first pulse;
- auto-EOI clears that bit after the second pulse;
- a spurious acknowledge leaves the in-service state untouched;
- each vector strobe lasts a single cycle.

Some behaviours only the bench scenarios can show, through a behavioural model compared every cycle plus directed vector checks:
- the vector value itself;
- the routing to the slave through the cascade code;
- preemption by a higher input while a lower one is in service;
- which bit a non-specific EOI removes;
- the spurious vector after a level request drops.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_P1, SEQ_P2} seq_t;
  localparam logic [1:0] ADDR_BASE = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
  localparam logic [1:0] ADDR_EOI  = 2'd3;
endpackage

// File: rtl/cic_prio_pick.sv
module cic_prio_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  isr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // busy[i]: some in-service bit at priority i or higher
  logic [N-1:0] busy;
  assign busy[0] = isr[0];
  generate
    for (genvar i = 1; i < N; i++) begin : g_busy
      assign busy[i] = busy[i-1] | isr[i];
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i] && !busy[i]) begin
        hit = 1'b1;
        idx = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/cic_ack_seq.sv
module cic_ack_seq
  import cic_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ack_req,
  output logic ack1,
  output logic ack2
);
  seq_t st;

  always_ff @(posedge clk) begin
    if (rst) st <= SEQ_IDLE;
    else begin
      unique case (st)
        SEQ_IDLE: if (ack_req) st <= SEQ_P1;
        SEQ_P1:   st <= SEQ_P2;
        default:  st <= SEQ_IDLE;
      endcase
    end
  end

  assign ack1 = (st == SEQ_P1);
  assign ack2 = (st == SEQ_P2);

  // R5
  pulse_pair_chk: assert property (@(posedge clk) disable iff (rst) ack1 |=> ack2);
  // R5
  no_reentry_chk: assert property (@(posedge clk) disable iff (rst) ack2 |=> !ack1);
endmodule

// File: rtl/cic_pic_unit.sv
module cic_pic_unit
  import cic_pkg::*;
#(
  parameter int N = 8,
  parameter int VW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  lines,
  input  logic [N-1:0]  ext_sel,
  input  logic [N-1:0]  ext_pend,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [VW-1:0] wr_data,
  input  logic          ack1,
  input  logic          ack2,
  output logic          pick_hit,
  output logic [IW-1:0] pick_idx,
  output logic [VW-1:0] vector
);
  logic [N-1:0]     irr, isr, mask, prev;
  logic [VW-IW-1:0] base;
  logic             aeoi, level;
  logic [IW-1:0]    cur_idx;
  logic             cur_hit;
  logic [N-1:0]     pend, set_v, clr_lv, claim, aeoi_clr, eoi_clr;
  logic             eoi_w;

  assign pend = ((irr & ~ext_sel) | (ext_pend & ext_sel)) & ~mask;

  cic_prio_pick #(.N(N)) u_pick (
    .pend (pend),
    .isr  (isr),
    .hit  (pick_hit),
    .idx  (pick_idx)
  );

  assign eoi_w    = wr_en && (wr_addr == ADDR_EOI);
  assign set_v    = level ? lines : (lines & ~prev);
  assign clr_lv   = level ? ~lines : '0;
  assign claim    = (ack1 && pick_hit) ? (N'(1) << pick_idx) : '0;
  assign aeoi_clr = (ack2 && aeoi && cur_hit) ? (N'(1) << cur_idx) : '0;
  assign eoi_clr  = eoi_w ? (isr & (~isr + N'(1))) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr <= '0; isr <= '0; mask <= '0; prev <= '0;
      base <= '0; aeoi <= 1'b0; level <= 1'b0;
      cur_idx <= '0; cur_hit <= 1'b0;
    end else begin
      prev <= lines;
      irr  <= (irr | set_v) & ~clr_lv & ~claim;
      isr  <= (isr | claim) & ~aeoi_clr & ~eoi_clr;
      if (ack1) begin
        cur_idx <= pick_hit ? pick_idx : '1;
        cur_hit <= pick_hit;
      end
      if (wr_en) begin
        unique case (wr_addr)
          ADDR_BASE: base <= wr_data[VW-1:IW];
          ADDR_MASK: mask <= wr_data[N-1:0];
          ADDR_MODE: begin aeoi <= wr_data[0]; level <= wr_data[1]; end
          default: ;
        endcase
      end
    end
  end

  assign vector = {base, cur_idx};

  // R6
  claim_sets_isr_chk: assert property (@(posedge clk) disable iff (rst)
    ack1 && pick_hit |=> isr[$past(pick_idx)]);
  // R6
  claim_clears_irr_chk: assert property (@(posedge clk) disable iff (rst)
    ack1 && pick_hit && !level |=> !irr[$past(pick_idx)]);
  // R10
  aeoi_release_chk: assert property (@(posedge clk) disable iff (rst)
    ack2 && aeoi && cur_hit |=> !isr[$past(cur_idx)]);
  // R9
  spurious_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ack1 && !pick_hit && !eoi_w |=> isr == $past(isr));
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int N_IN = 8,
  parameter int CASC_IDX = 2,
  parameter int VW = 8,
  localparam int IW = $clog2(N_IN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*N_IN-1:0] irq_in,
  input  logic              wr_en,
  input  logic              wr_slave,
  input  logic [1:0]        wr_addr,
  input  logic [VW-1:0]     wr_data,
  input  logic              ack_req,
  output logic              int_out,
  output logic              vec_valid,
  output logic [VW-1:0]     vec_data
);
  localparam logic [N_IN-1:0] CASC_MASK = N_IN'(1) << CASC_IDX;
  localparam logic [IW-1:0]   CASC_CODE = IW'(CASC_IDX);

  logic ack1, ack2, s_ack1, s_ack2;
  logic m_hit, s_hit;
  logic [IW-1:0] m_idx, s_idx_unused, casc_code;
  logic [VW-1:0] m_vec, s_vec;
  logic unused_casc_pin;

  assign unused_casc_pin = irq_in[CASC_IDX];

  cic_ack_seq u_seq (
    .clk(clk), .rst(rst), .ack_req(ack_req), .ack1(ack1), .ack2(ack2)
  );

  assign s_ack1 = ack1 && m_hit && (m_idx == CASC_CODE);
  assign s_ack2 = ack2 && (casc_code == CASC_CODE);

  cic_pic_unit #(.N(N_IN), .VW(VW)) u_master (
    .clk(clk), .rst(rst),
    .lines(irq_in[N_IN-1:0] & ~CASC_MASK),
    .ext_sel(CASC_MASK),
    .ext_pend({N_IN{s_hit}} & CASC_MASK),
    .wr_en(wr_en && !wr_slave), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack1(ack1), .ack2(ack2),
    .pick_hit(m_hit), .pick_idx(m_idx), .vector(m_vec)
  );

  cic_pic_unit #(.N(N_IN), .VW(VW)) u_slave (
    .clk(clk), .rst(rst),
    .lines(irq_in[2*N_IN-1:N_IN]),
    .ext_sel('0), .ext_pend('0),
    .wr_en(wr_en && wr_slave), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack1(s_ack1), .ack2(s_ack2),
    .pick_hit(s_hit), .pick_idx(s_idx_unused), .vector(s_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      casc_code <= '0;
      int_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      if (ack1) casc_code <= m_hit ? m_idx : '1;
      int_out   <= m_hit;
      vec_valid <= ack2;
      if (ack2) vec_data <= s_ack2 ? s_vec : m_vec;
    end
  end

  // R7
  vec_single_chk: assert property (@(posedge clk) disable iff (rst) vec_valid |=> !vec_valid);
  // R7
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (rst) ack2 |=> vec_valid);
  // R8
  slave_gate_chk: assert property (@(posedge clk) disable iff (rst)
    s_ack1 |-> s_hit);
endmodule

// File: tb/cascade_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic wr_en = 1'b0, wr_slave = 1'b0, ack_req = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic int_out, vec_valid;
  logic [7:0] vec_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cascade_irq_ctrl u_cascade_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_slave(wr_slave),
    .wr_addr(wr_addr), .wr_data(wr_data), .ack_req(ack_req),
    .int_out(int_out), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] q_irr[2], q_isr[2], q_mask[2], q_prev[2];
  logic [4:0] q_base[2];
  bit q_aeoi[2], q_lvl[2], q_curv[2];
  int q_cur[2];
  int q_st, q_casc;
  bit exp_int, exp_vv;
  logic [7:0] exp_vd;

  function automatic int first_ok(logic [7:0] pend, logic [7:0] isr);
    for (int i = 0; i < 8; i++) begin
      if (isr[i]) return -1;
      if (pend[i]) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        q_irr[c] = 0; q_isr[c] = 0; q_mask[c] = 0; q_prev[c] = 0;
        q_base[c] = 0; q_aeoi[c] = 0; q_lvl[c] = 0; q_curv[c] = 0; q_cur[c] = 0;
      end
      q_st = 0; q_casc = 0; exp_int = 0; exp_vv = 0; exp_vd = 0;
    end else begin
      logic [7:0] ln[2];
      logic [7:0] pend0, old_isr;
      int sp, mp, claim;
      bit a1, a2, k2;
      ln[0] = irq_in[7:0] & 8'hFB;
      ln[1] = irq_in[15:8];
      sp = first_ok(q_irr[1] & ~q_mask[1], q_isr[1]);
      pend0 = (q_irr[0] & 8'hFB) | ((sp >= 0) ? 8'h04 : 8'h00);
      mp = first_ok(pend0 & ~q_mask[0], q_isr[0]);
      a1 = (q_st == 1); a2 = (q_st == 2);
      exp_int = (mp >= 0);
      exp_vv = a2;
      if (a2) exp_vd = (q_casc == 2) ? {q_base[1], 3'(q_cur[1])} : {q_base[0], 3'(q_cur[0])};
      for (int c = 0; c < 2; c++) begin
        claim = -1;
        if (a1 && c == 0) begin claim = mp; q_cur[0] = (mp >= 0) ? mp : 7; q_curv[0] = (mp >= 0); end
        if (a1 && c == 1 && mp == 2) begin claim = sp; q_cur[1] = sp; q_curv[1] = 1; end
        k2 = a2 && (c == 0 || q_casc == 2);
        old_isr = q_isr[c];
        if (claim >= 0) q_isr[c][claim] = 1'b1;
        if (k2 && q_aeoi[c] && q_curv[c]) q_isr[c][q_cur[c]] = 1'b0;
        if (wr_en && int'(wr_slave) == c && wr_addr == 2'd3)
          for (int i = 0; i < 8; i++) if (old_isr[i]) begin q_isr[c][i] = 1'b0; break; end
        for (int i = 0; i < 8; i++) begin
          if (q_lvl[c]) q_irr[c][i] = ln[c][i];
          else if (ln[c][i] && !q_prev[c][i]) q_irr[c][i] = 1'b1;
        end
        if (claim >= 0) q_irr[c][claim] = 1'b0;
        if (wr_en && int'(wr_slave) == c) begin
          if (wr_addr == 2'd0) q_base[c] = wr_data[7:3];
          if (wr_addr == 2'd1) q_mask[c] = wr_data;
          if (wr_addr == 2'd2) begin q_aeoi[c] = wr_data[0]; q_lvl[c] = wr_data[1]; end
        end
        q_prev[c] = ln[c];
      end
      if (a1) q_casc = (mp >= 0) ? mp : 7;
      if (q_st == 0 && ack_req) q_st = 1;
      else if (q_st == 1) q_st = 2;
      else q_st = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R3 int_out vs model", int'(int_out), int'(exp_int));
    chk("R7 vec_valid vs model", int'(vec_valid), int'(exp_vv));
    if (exp_vv) chk("R1 vec_data vs model", int'(vec_data), int'(exp_vd));
  end

  // ---------------- drivers ----------------
  task automatic wr(bit sl, logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_slave = sl; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic pulse(int i);
    @(negedge clk); irq_in[i] = 1'b1;
    @(negedge clk); irq_in[i] = 1'b0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack_req = 1;
    @(negedge clk); ack_req = 0;
    @(negedge clk);
    @(negedge clk); v = vec_data;
    chk("R7 strobe on third cycle", int'(vec_valid), 1);
  endtask

  initial begin
    logic [7:0] v;
    int cnt;
    idle(3);
    @(negedge clk); rst = 0;
    chk("R3 reset int_out", int'(int_out), 0);
    chk("R7 reset vec_valid", int'(vec_valid), 0);
    wr(0, 2'd0, 8'h20);
    wr(1, 2'd0, 8'h28);
    // edge request, vector composition
    pulse(5); idle(2);
    chk("R2 edge sets request", int'(int_out), 1);
    do_ack(v); chk("R1 master vector input 5", int'(v), 8'h25);
    chk("R6 request consumed", int'(int_out), 0);
    do_ack(v); chk("R9 spurious vector", int'(v), 8'h27);
    wr(0, 2'd3, 0);
    // fixed priority and blocking
    @(negedge clk); irq_in[1] = 1; irq_in[3] = 1;
    @(negedge clk); irq_in[1] = 0; irq_in[3] = 0;
    idle(2);
    do_ack(v); chk("R4 input 1 beats 3", int'(v), 8'h21);
    idle(1); chk("R4 lower blocked by service", int'(int_out), 0);
    wr(0, 2'd3, 0); idle(2);
    chk("R11 EOI releases lower", int'(int_out), 1);
    do_ack(v); chk("R4 then input 3", int'(v), 8'h23);
    wr(0, 2'd3, 0);
    // cascade
    pulse(12); idle(2);
    chk("R8 slave raises int_out", int'(int_out), 1);
    do_ack(v); chk("R8 slave vector", int'(v), 8'h2C);
    wr(1, 2'd3, 0); wr(0, 2'd3, 0);
    pulse(2); idle(3);
    chk("R8 irq_in[2] no effect", int'(int_out), 0);
    // level mode, vanished request
    wr(0, 2'd2, 8'h02);
    @(negedge clk); irq_in[6] = 1; idle(3);
    chk("R2 level request pending", int'(int_out), 1);
    @(negedge clk); irq_in[6] = 0; ack_req = 1;
    @(negedge clk); ack_req = 0;
    idle(2); chk("R9 dropped level gives spurious", int'(vec_data), 8'h27);
    wr(0, 2'd2, 8'h00);
    // auto-EOI
    wr(0, 2'd2, 8'h01);
    pulse(4); idle(2);
    do_ack(v); chk("R10 aeoi vector", int'(v), 8'h24);
    pulse(4); idle(2);
    chk("R10 no EOI needed", int'(int_out), 1);
    do_ack(v);
    wr(0, 2'd2, 8'h00);
    // mask
    wr(0, 2'd1, 8'h01);
    pulse(0); idle(2);
    chk("R3 masked input silent", int'(int_out), 0);
    wr(0, 2'd1, 8'h00); idle(2);
    chk("R3 unmask shows held request", int'(int_out), 1);
    do_ack(v); chk("R1 input 0 vector", int'(v), 8'h20);
    wr(0, 2'd3, 0);
    // EOI selects the highest-priority in-service bit
    pulse(3); idle(2); do_ack(v);
    pulse(4); idle(2);
    chk("R4 input 4 blocked by 3", int'(int_out), 0);
    pulse(1); idle(2);
    chk("R4 higher preempts", int'(int_out), 1);
    do_ack(v); chk("R4 preempt vector", int'(v), 8'h21);
    wr(0, 2'd3, 0);
    pulse(1); idle(2);
    chk("R11 EOI cleared input 1 first", int'(int_out), 1);
    do_ack(v); wr(0, 2'd3, 0); wr(0, 2'd3, 0); idle(2);
    chk("R11 second EOI frees input 4", int'(int_out), 1);
    do_ack(v); chk("R11 input 4 vector", int'(v), 8'h24);
    wr(0, 2'd3, 0);
    // ack while busy is ignored
    pulse(7); idle(2);
    @(negedge clk); ack_req = 1;
    @(negedge clk);
    cnt = 0;
    @(negedge clk); ack_req = 0;
    for (int i = 0; i < 8; i++) begin
      if (vec_valid) cnt++;
      @(negedge clk);
    end
    chk("R5 one sequence per busy ack", cnt, 1);
    wr(0, 2'd3, 0);
    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule